// File: doc/BRIEF.md
# Output Clock Divider with Stepped Power-Down

This block takes a fast oscillator clock and produces a divided output clock. A 2-bit code selects the normal divide ratio: 1, 2, 4 or 8. The output always has a 50% duty cycle. A power-down request adds more division on top of the programmed ratio, up to a factor of sixteen. The extra division does not change all at once. A small sequencer running on the slower reference clock moves it one doubling or halving per reference period. Entry and exit therefore take place in four discrete steps each, and the output frequency changes slowly.

The sequencer keeps a step index from 0 to 4. The extra division is two raised to that index. The index is Gray-coded, registered, and passed into the oscillator domain through a synchronizer chain. The divider adds the synchronized step to the ratio code to form a total exponent. It loads that exponent only at the last count of a full output period. The new setting therefore starts on a rising output edge, and no high or low phase is ever cut short. The step index is also brought out as status in the reference-clock domain.

`ratio_sel` is treated as synchronous to `vco_clk`, and `pd_req` as synchronous to `ref_clk`.

Top module: `pdstep_divider`

## Requirements
- R1: With the step index at 0 and the design settled, ratio code k (0..3) gives an output period of 2^k oscillator cycles: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R2: Every output period has equal high and low time. For a span of 1, the output follows the oscillator clock.
- R3: While `pd_req` is high, `step_idx` rises by exactly one on each `ref_clk` rising edge until it reaches 4, and then it holds at 4.
- R4: While `pd_req` is low, `step_idx` falls by exactly one on each `ref_clk` rising edge until it reaches 0, so a full exit takes four steps. After the exit settles, the programmed period returns.
- R5: With `step_idx` at 4 and the design settled, the output period is 16 times the programmed span (2^(k+4) oscillator cycles).
- R6: If `pd_req` changes direction mid-sequence, `step_idx` continues from its current value. It never moves by more than one per reference edge and never leaves 0..4. The synchronized Gray copy changes by at most one bit per oscillator cycle.
- R7: The applied span changes only at the end of a complete output period. During any stepping sequence, each observed period is a power of two between the programmed span and 16 times it, with equal high and low phases.
- R8: Reset clears the step index to 0 (extra division 1) and clears the divider counter. The first full period after reset uses the programmed span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock to be divided |
| ref_clk | input | 1 | Slow reference clock that paces the step sequencer |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ratio_sel | input | 2 | Programmed divide code k, span 2^k (synchronous to vco_clk) |
| pd_req | input | 1 | Power-down request, high to slow down (synchronous to ref_clk) |
| clk_out | output | 1 | Divided output clock |
| step_idx | output | 3 | Current power-down step 0..4 in the ref_clk domain |

## Verification
The bench builds the block with its defaults: a 2-bit ratio code, four power-down steps and a two-stage synchronizer. These settings make the largest span 2^7 = 128 oscillator cycles, which the bench reaches with code 3 at full power-down. The bench also covers the span of 1, where the output mux hands over to the raw oscillator clock. Separately from the steady-state period checks, consecutive periods are measured while steps are being applied in both directions. This exposes any shortened phase produced by a span change that lands off a period boundary.

// File: rtl/pdstep_pkg.sv
package pdstep_pkg;

  // number of oscillator cycles in one output period for exponent e
  function automatic int unsigned span_of(input int unsigned e);
    return 32'd1 << e;
  endfunction

  // binary to reflected Gray
  function automatic int unsigned gray_of(input int unsigned b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray back to binary via prefix xor
  function automatic int unsigned bin_of_gray(input int unsigned g);
    int unsigned b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

endpackage

// File: rtl/pdstep_seq.sv
module pdstep_seq #(
  parameter int STEP_W   = 3,
  parameter int STEP_MAX = 4
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              pd_req,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_gray_q
);
  import pdstep_pkg::*;

  logic [STEP_W-1:0] step_nxt;
  logic              at_top, at_floor;

  assign at_top   = (step_q == STEP_W'(STEP_MAX));
  assign at_floor = (step_q == '0);

  always_comb begin
    step_nxt = step_q;
    if (pd_req && !at_top)        step_nxt = step_q + 1'b1;
    else if (!pd_req && !at_floor) step_nxt = step_q - 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= '0;
      step_gray_q <= '0;
    end else begin
      step_q      <= step_nxt;
      step_gray_q <= STEP_W'(gray_of(32'(step_nxt)));
    end
  end
endmodule

// File: rtl/pdstep_sync.sv
module pdstep_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdstep_core.sv
module pdstep_core #(
  parameter int EXP_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             vco_clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_target,
  output logic [EXP_W-1:0] exp_applied,
  output logic             period_end,
  output logic             div_q
);
  import pdstep_pkg::*;

  logic [CNT_W-1:0] cnt, cnt_inc, last_cnt, half_cnt;

  assign last_cnt   = CNT_W'(span_of(32'(exp_applied)) - 32'd1);
  assign half_cnt   = CNT_W'(span_of(32'(exp_applied)) >> 1);
  assign cnt_inc    = cnt + 1'b1;
  assign period_end = (cnt == last_cnt);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      exp_applied <= '0;
      div_q       <= 1'b0;
    end else if (period_end) begin
      cnt         <= '0;
      exp_applied <= exp_target;
      div_q       <= 1'b1;
    end else begin
      cnt   <= cnt_inc;
      div_q <= (cnt_inc < half_cnt);
    end
  end
endmodule

// File: rtl/pdstep_divider.sv
module pdstep_divider #(
  parameter int RATIO_W     = 2,
  parameter int PD_STEPS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               vco_clk,
  input  logic                               ref_clk,
  input  logic                               rst_n,
  input  logic [RATIO_W-1:0]                 ratio_sel,
  input  logic                               pd_req,
  output logic                               clk_out,
  output logic [$clog2(PD_STEPS+1)-1:0]      step_idx
);
  import pdstep_pkg::*;

  localparam int STEP_W  = $clog2(PD_STEPS + 1);
  localparam int EXP_MAX = (2 ** RATIO_W) - 1 + PD_STEPS;
  localparam int EXP_W   = $clog2(EXP_MAX + 1);
  localparam int CNT_W   = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [STEP_W-1:0] step_gray_r, step_gray_v, step_v;
  logic [EXP_W-1:0]  exp_target, exp_applied;
  logic              period_end, div_q;

  pdstep_seq #(.STEP_W(STEP_W), .STEP_MAX(PD_STEPS)) u_seq (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .step_q      (step_idx),
    .step_gray_q (step_gray_r)
  );

  pdstep_sync #(.W(STEP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .d     (step_gray_r),
    .q     (step_gray_v)
  );

  assign step_v     = STEP_W'(bin_of_gray(32'(step_gray_v)));
  assign exp_target = EXP_W'(ratio_sel) + EXP_W'(step_v);

  pdstep_core #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_core (
    .vco_clk     (vco_clk),
    .rst_n       (rst_n),
    .exp_target  (exp_target),
    .exp_applied (exp_applied),
    .period_end  (period_end),
    .div_q       (div_q)
  );

  // span of one passes the oscillator through; switching only at a
  // period boundary keeps both mux legs high across the handover
  assign clk_out = (exp_applied == '0) ? vco_clk : div_q;
endmodule

// File: rtl/pdstep_chk.sv
module pdstep_chk #(
  parameter int STEP_W   = 3,
  parameter int STEP_MAX = 4,
  parameter int EXP_W    = 3
) (
  input logic              vco_clk,
  input logic              ref_clk,
  input logic              rst_n,
  input logic              pd_req,
  input logic [STEP_W-1:0] step_idx,
  input logic [STEP_W-1:0] step_gray_v,
  input logic [EXP_W-1:0]  exp_applied,
  input logic              period_end
);
  a_r3_step_up: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pd_req && step_idx < STEP_W'(STEP_MAX)) |=> (step_idx == $past(step_idx) + 1'b1));

  a_r3_hold_at_max: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pd_req && step_idx == STEP_W'(STEP_MAX)) |=> (step_idx == STEP_W'(STEP_MAX)));

  a_r4_step_down: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!pd_req && step_idx != '0) |=> (step_idx == $past(step_idx) - 1'b1));

  a_r6_step_in_range: assert property (@(posedge ref_clk) disable iff (!rst_n)
    step_idx <= STEP_W'(STEP_MAX));

  a_r6_gray_single_bit: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $countones(step_gray_v ^ $past(step_gray_v)) <= 1);

  a_r7_change_at_boundary: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !period_end |=> $stable(exp_applied));
endmodule

bind pdstep_divider pdstep_chk #(.STEP_W(STEP_W), .STEP_MAX(PD_STEPS), .EXP_W(EXP_W)) u_chk (
  .vco_clk     (vco_clk),
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .pd_req      (pd_req),
  .step_idx    (step_idx),
  .step_gray_v (step_gray_v),
  .exp_applied (exp_applied),
  .period_end  (period_end)
);

// File: tb/tb_pdstep_divider.sv
`timescale 1ns/1ps
module tb_pdstep_divider;
  logic       vco_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, pd_req = 1'b0;
  logic [1:0] ratio_sel = 2'd2;
  logic       clk_out;
  logic [2:0] step_idx;

  int total = 0, bad = 0, pushed = 0, served = 0;
  bit finished = 0;

  typedef struct { int lo; int hi; string req; } item_t;
  item_t sb_q[$];

  always #2  vco_clk = ~vco_clk;  // 250 MHz
  always #20 ref_clk = ~ref_clk;

  pdstep_divider dut (.vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .ratio_sel(ratio_sel), .pd_req(pd_req), .clk_out(clk_out), .step_idx(step_idx));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: push expected period range, wait until monitor consumed it
  task automatic expect_span(input int lo, input int hi, input string req);
    item_t it;
    it.lo = lo; it.hi = hi; it.req = req;
    sb_q.push_back(it);
    pushed++;
    wait (served == pushed);
  endtask

  // monitor: one full output period per queued item
  initial begin
    forever begin
      item_t it;
      time t0, t1, t2;
      int per;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      @(posedge clk_out); t0 = $time;
      @(negedge clk_out); t1 = $time;
      @(posedge clk_out); t2 = $time;
      per = int'((t2 - t0) / 4);
      check(per >= it.lo && per <= it.hi && (per & (per - 1)) == 0, it.req, per, it.lo);
      check((t1 - t0) * 2 == (t2 - t0), "R2", int'(t1 - t0), int'((t2 - t0) / 2));
      served++;
    end
  end

  task automatic vco_wait(input int n);
    repeat (n) @(posedge vco_clk);
  endtask

  task automatic set_ratio(input int k);
    @(negedge vco_clk); ratio_sel = 2'(k);
  endtask

  initial begin
    #400us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge ref_clk);
    check(step_idx == 3'd0, "R8", step_idx, 0);
    #3 rst_n = 1'b1;
    vco_wait(20);
    expect_span(4, 4, "R8");

    // R1: every ratio code, no power-down
    for (int k = 0; k < 4; k++) begin
      set_ratio(k);
      vco_wait(300);
      expect_span(1 << k, 1 << k, "R1");
    end

    // R3: ramp up one per ref edge, then saturate
    set_ratio(1);
    vco_wait(50);
    @(negedge ref_clk); pd_req = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge ref_clk);
      check(step_idx == 3'(i), "R3", step_idx, i);
    end
    @(negedge ref_clk);
    check(step_idx == 3'd4, "R3", step_idx, 4);
    vco_wait(300);
    expect_span(32, 32, "R5");

    // R4: four steps back down
    @(negedge ref_clk); pd_req = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      @(negedge ref_clk);
      check(step_idx == 3'(i), "R4", step_idx, i);
    end
    vco_wait(300);
    expect_span(2, 2, "R4");

    // R5: largest span
    set_ratio(3);
    @(negedge ref_clk); pd_req = 1'b1;
    vco_wait(600);
    expect_span(128, 128, "R5");
    @(negedge ref_clk); pd_req = 1'b0;
    vco_wait(600);
    expect_span(8, 8, "R4");

    // R6: reverse mid-sequence
    set_ratio(0);
    vco_wait(50);
    @(negedge ref_clk); pd_req = 1'b1;
    @(negedge ref_clk); check(step_idx == 3'd1, "R6", step_idx, 1);
    @(negedge ref_clk); check(step_idx == 3'd2, "R6", step_idx, 2);
    pd_req = 1'b0;
    @(negedge ref_clk); check(step_idx == 3'd1, "R6", step_idx, 1);
    @(negedge ref_clk); check(step_idx == 3'd0, "R6", step_idx, 0);
    vco_wait(50);
    expect_span(1, 1, "R6");

    // R7: periods observed while steps are being applied
    set_ratio(1);
    vco_wait(50);
    @(negedge ref_clk); pd_req = 1'b1;
    for (int i = 0; i < 8; i++) expect_span(2, 32, "R7");
    @(negedge ref_clk); pd_req = 1'b0;
    for (int i = 0; i < 8; i++) expect_span(2, 32, "R7");
    vco_wait(200);
    expect_span(2, 2, "R7");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule